// File: doc/BRIEF.md
# 32-Pin GPIO Port Controller

This block drives and samples 32 general-purpose pins through a small word-wide register bus. Software writes an output-value word, an enable word and an open-drain word. Each pin then either drives its value (push-pull), pulls low only (open-drain) or floats. The block also presents the synchronised pin levels in an input word that software can read.

Each pin has two 2-bit select fields. One picks the source of the pin's output value and the other picks the source of its enable. Code 0 keeps the pin on the register path. Codes 1 to 3 take the value or enable from one of three alternate-function vectors supplied by neighbouring logic. Three receive words and six input-select words are provided as plain storage beside the pin registers.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads zero and every bit of `pad_oe` is 0, so all pins float on the register path.
- R2: The word addresses are fixed as follows:
  - 0 output value
  - 1 enable
  - 2 value-select low
  - 3 value-select high
  - 4 enable-select low
  - 5 enable-select high
  - 6 open-drain
  - 7 input
  - 8, 9, 10 receive 1 to 3
  - 11 reserved
  - 12 to 17 input-select words 1L, 1H, 2L, 2H, 3L, 3H

  A write to any writable word is read back unchanged.
- R3: Pin n uses bit 31-n of every one-bit-per-pin word, and of `pin_in`, `pad_out`, `pad_oe` and the six alternate vectors. Pin 0 is the MSB.
- R4: On the register path (both select fields 0) with open-drain bit 0, `pad_oe` equals the pin's enable bit and `pad_out` equals its output-value bit. An enable bit of 0 floats the pin.
- R5: With the open-drain bit set, the pin is driven (`pad_oe`=1, `pad_out`=0) only when the selected value is 0 and the selected enable is 1. Otherwise `pad_oe` is 0 and `pad_out` is 0.
- R6: Pins 0 to 15 take their select fields from the low select word and pins 16 to 31 from the high word. Within that word, pin n's field is bits [31-2(n mod 16) : 30-2(n mod 16)].
- R7: A value-select code k in 1..3 takes the pin's value from `alt_valk`. An enable-select code k in 1..3 takes its enable from `alt_enk`. Code 0 uses the registers.
- R8: A change on `pin_in` that is set up before clock edge E appears in the input word after edge E+1, and not after edge E alone.
- R9: Writes to the input word and to the reserved word have no effect. The reserved word and any address above 17 read zero.
- R10: The receive and input-select words hold whatever is written to them and have no effect on `pad_out` or `pad_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Word address |
| bus_we | input | 1 | Write strobe; the write occurs at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Raw pin levels |
| alt_val1 | input | 32 | Alternate output value, source 1 |
| alt_val2 | input | 32 | Alternate output value, source 2 |
| alt_val3 | input | 32 | Alternate output value, source 3 |
| alt_en1 | input | 32 | Alternate output enable, source 1 |
| alt_en2 | input | 32 | Alternate output enable, source 2 |
| alt_en3 | input | 32 | Alternate output enable, source 3 |
| pad_out | output | 32 | Value driven to each pad |
| pad_oe | output | 32 | Pad driver enable, 1 = driving |

## Verification
The pin function is exercised with several patterns:
- Single-bit patterns at pins 0 and 31 show whether the bit order is reversed.
- Split patterns, such as upper half enabled with alternating values, separate the value path from the enable path.
- An all-open-drain pattern crossed with complementary value and enable bytes covers each of the four open-drain cases.
- Select codes placed at pins 0, 15, 16 and 31 land at the ends of both select words, so a shifted field or a swapped half is caught.
- The three alternate vectors are given distinct values, so a swapped code changes the result.
- A pin edge is sampled one and two clocks later to fix the synchroniser depth.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int NPINS   = 32;
  localparam int WORD_W  = 32;
  localparam int SEL_W   = 2;
  localparam int SEL_PER_WORD = WORD_W / SEL_W;
  localparam int NWORDS  = 18;

  localparam int A_OUT  = 0;
  localparam int A_EN   = 1;
  localparam int A_VSL  = 2;
  localparam int A_VSH  = 3;
  localparam int A_ESL  = 4;
  localparam int A_ESH  = 5;
  localparam int A_OD   = 6;
  localparam int A_IN   = 7;
  localparam int A_RSV  = 11;

  // bit position of a pin in any one-bit-per-pin vector (MSB-first)
  function automatic int pin_bit(input int pin);
    return NPINS - 1 - pin;
  endfunction

  // top bit of the 2-bit select field for a pin inside its word
  function automatic int sel_top(input int pin);
    return WORD_W - 1 - SEL_W * (pin % SEL_PER_WORD);
  endfunction

  function automatic logic [SEL_W-1:0] sel_field(input logic [WORD_W-1:0] lo,
                                                 input logic [WORD_W-1:0] hi,
                                                 input int pin);
    logic [WORD_W-1:0] w;
    w = (pin < SEL_PER_WORD) ? lo : hi;
    return w[sel_top(pin) -: SEL_W];
  endfunction

  function automatic bit word_writable(input int idx);
    return (idx < NWORDS) && (idx != A_IN) && (idx != A_RSV);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];

  // cycles since reset, saturating, so the latency check never looks before reset
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  if (STAGES == 2) begin : g_chk2
    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2) |-> (dout == $past(din, 2))); // R8
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [WORD_W-1:0] in_sync,
  output logic [WORD_W-1:0] out_q,
  output logic [WORD_W-1:0] en_q,
  output logic [WORD_W-1:0] vsl_q,
  output logic [WORD_W-1:0] vsh_q,
  output logic [WORD_W-1:0] esl_q,
  output logic [WORD_W-1:0] esh_q,
  output logic [WORD_W-1:0] od_q
);
  logic [WORD_W-1:0] regs_q [NWORDS];
  logic [NWORDS-1:0] wr_hit;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign wr_hit[w] = bus_we && (bus_addr == ADDR_W'(w));
    if (word_writable(w)) begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n)         regs_q[w] <= '0;
        else if (wr_hit[w]) regs_q[w] <= bus_wdata;
      end
    end else begin : g_ro
      assign regs_q[w] = '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (bus_addr == ADDR_W'(w)) bus_rdata = (w == A_IN) ? in_sync : regs_q[w];
    end
  end

  assign out_q = regs_q[A_OUT];
  assign en_q  = regs_q[A_EN];
  assign vsl_q = regs_q[A_VSL];
  assign vsh_q = regs_q[A_VSH];
  assign esl_q = regs_q[A_ESL];
  assign esh_q = regs_q[A_ESH];
  assign od_q  = regs_q[A_OD];

  AST_RSV_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(A_RSV)) |-> (bus_rdata == '0)); // R9
  AST_OUT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[A_OUT] |=> (out_q == $past(bus_wdata))); // R2
  AST_OD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit[A_OD] |=> $stable(od_q)); // R2
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] out_q,
  input  logic [WORD_W-1:0] en_q,
  input  logic [WORD_W-1:0] vsl_q,
  input  logic [WORD_W-1:0] vsh_q,
  input  logic [WORD_W-1:0] esl_q,
  input  logic [WORD_W-1:0] esh_q,
  input  logic [WORD_W-1:0] od_q,
  input  logic [NPINS-1:0]  alt_val1,
  input  logic [NPINS-1:0]  alt_val2,
  input  logic [NPINS-1:0]  alt_val3,
  input  logic [NPINS-1:0]  alt_en1,
  input  logic [NPINS-1:0]  alt_en2,
  input  logic [NPINS-1:0]  alt_en3,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  // selected value and enable per pin, before open-drain resolution
  logic [NPINS-1:0] sel_val;
  logic [NPINS-1:0] sel_en;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int B = pin_bit(p);
    logic [SEL_W-1:0] vcode, ecode;
    assign vcode = sel_field(vsl_q, vsh_q, p);
    assign ecode = sel_field(esl_q, esh_q, p);

    always_comb begin
      unique case (vcode)
        2'd1:    sel_val[B] = alt_val1[B];
        2'd2:    sel_val[B] = alt_val2[B];
        2'd3:    sel_val[B] = alt_val3[B];
        default: sel_val[B] = out_q[B];
      endcase
      unique case (ecode)
        2'd1:    sel_en[B] = alt_en1[B];
        2'd2:    sel_en[B] = alt_en2[B];
        2'd3:    sel_en[B] = alt_en3[B];
        default: sel_en[B] = en_q[B];
      endcase
    end

    assign pad_oe[B]  = od_q[B] ? (sel_en[B] & ~sel_val[B]) : sel_en[B];
    assign pad_out[B] = od_q[B] ? 1'b0 : sel_val[B];

    AST_GPIO_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      (ecode == 2'd0 && !en_q[B]) |-> !pad_oe[B]); // R4
    AST_ALT1_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (vcode == 2'd1 && !od_q[B]) |-> (pad_out[B] == alt_val1[B])); // R7
  end

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & od_q) == '0)); // R5
  AST_OD_ONLY_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & od_q & sel_val) == '0)); // R5
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pin_in,
  input  logic [31:0] alt_val1,
  input  logic [31:0] alt_val2,
  input  logic [31:0] alt_val3,
  input  logic [31:0] alt_en1,
  input  logic [31:0] alt_en2,
  input  logic [31:0] alt_en3,
  output logic [31:0] pad_out,
  output logic [31:0] pad_oe
);
  import gpio_port_pkg::*;

  logic [WORD_W-1:0] in_sync;
  logic [WORD_W-1:0] out_q, en_q, vsl_q, vsh_q, esl_q, esh_q, od_q;

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(in_sync)
  );

  gpio_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_sync(in_sync),
    .out_q(out_q), .en_q(en_q), .vsl_q(vsl_q), .vsh_q(vsh_q),
    .esl_q(esl_q), .esh_q(esh_q), .od_q(od_q)
  );

  gpio_pin_mux u_mux (
    .clk(clk), .rst_n(rst_n),
    .out_q(out_q), .en_q(en_q), .vsl_q(vsl_q), .vsh_q(vsh_q),
    .esl_q(esl_q), .esh_q(esh_q), .od_q(od_q),
    .alt_val1(alt_val1), .alt_val2(alt_val2), .alt_val3(alt_val3),
    .alt_en1(alt_en1), .alt_en2(alt_en2), .alt_en3(alt_en3),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  AST_FLOAT_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0 && esl_q == '0 && esh_q == '0) |-> (pad_oe == '0)); // R1
endmodule

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
module gpio_port_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] alt_val1 = '0, alt_val2 = '0, alt_val3 = '0;
  logic [31:0] alt_en1 = '0, alt_en2 = '0, alt_en3 = '0;
  logic [31:0] pad_out, pad_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .alt_val1(alt_val1), .alt_val2(alt_val2), .alt_val3(alt_val3),
    .alt_en1(alt_en1), .alt_en2(alt_en2), .alt_en3(alt_en3),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a); bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a);
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] pbit(input int n);
    return 32'h1 << (31 - n);
  endfunction

  task automatic clear_all();
    for (int a = 0; a < 18; a++) if (a != 7 && a != 11) wr(a, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 18; a++) begin
      if (a == 7) continue;
      rd(a, d);
      check("R1 reset word", d, 32'h0);
    end
    check("R1 reset pad_oe", pad_oe, 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    for (int a = 0; a < 18; a++) begin
      if (a == 7 || a == 11) continue;
      wr(a, 32'h1357_0000 + 32'(a * 32'h111));
    end
    for (int a = 0; a < 18; a++) begin
      if (a == 7 || a == 11) continue;
      rd(a, d);
      check("R2 readback", d, 32'h1357_0000 + 32'(a * 32'h111));
    end
    clear_all();
  endtask

  task automatic t_bit_order();
    wr(0, pbit(0)); wr(1, pbit(0));
    @(negedge clk);
    check("R3 pin0 oe at MSB", pad_oe, 32'h8000_0000);
    check("R3 pin0 out at MSB", pad_out, 32'h8000_0000);
    wr(0, 32'h0); wr(1, pbit(31));
    @(negedge clk);
    check("R3 pin31 oe at LSB", pad_oe, 32'h0000_0001);
    wr(1, 32'h0);
  endtask

  task automatic t_push_pull();
    wr(0, 32'hA5A5_A5A5); wr(1, 32'hFFFF_0000);
    @(negedge clk);
    check("R4 oe follows enable", pad_oe, 32'hFFFF_0000);
    check("R4 out follows value", pad_out, 32'hA5A5_A5A5);
    wr(1, 32'h0);
    @(negedge clk);
    check("R4 float when enable clear", pad_oe, 32'h0);
  endtask

  task automatic t_open_drain();
    wr(6, 32'hFFFF_FFFF); wr(0, 32'h0F0F_0F0F); wr(1, 32'h00FF_00FF);
    @(negedge clk);
    check("R5 od oe", pad_oe, 32'h00FF_00FF & ~32'h0F0F_0F0F);
    check("R5 od out low", pad_out, 32'h0);
    wr(6, 32'h0000_FFFF);
    @(negedge clk);
    check("R5 mixed oe", pad_oe, (32'h00FF_00FF & 32'hFFFF_0000) |
                                  (32'h00FF_00FF & ~32'h0F0F_0F0F & 32'h0000_FFFF));
    check("R5 mixed out", pad_out, 32'h0F0F_0F0F & 32'hFFFF_0000);
    wr(6, 32'h0); wr(0, 32'h0); wr(1, 32'h0);
  endtask

  // expected value for a pin given a select code and the candidate vectors
  function automatic logic pick(input logic [1:0] code, input int n, input logic [31:0] r,
                                input logic [31:0] a1, input logic [31:0] a2, input logic [31:0] a3);
    logic [31:0] v;
    v = (code == 2'd1) ? a1 : (code == 2'd2) ? a2 : (code == 2'd3) ? a3 : r;
    return v[31 - n];
  endfunction

  task automatic t_select();
    logic [1:0] codes [32];
    logic [31:0] lo, hi, expv, expe;
    for (int n = 0; n < 32; n++) codes[n] = 2'd0;
    codes[0] = 2'd1; codes[15] = 2'd2; codes[16] = 2'd3; codes[31] = 2'd1; codes[7] = 2'd3;
    lo = '0; hi = '0;
    for (int n = 0; n < 32; n++) begin
      if (n < 16) lo |= 32'(codes[n]) << (30 - 2 * n);
      else        hi |= 32'(codes[n]) << (30 - 2 * (n - 16));
    end
    alt_val1 = 32'hFFFF_FFFF; alt_val2 = 32'h0001_0000; alt_val3 = 32'h0100_8000;
    alt_en1  = 32'h8000_0001; alt_en2  = 32'h0001_0000; alt_en3  = 32'h0000_0000;
    wr(0, 32'h0); wr(1, 32'hFFFF_FFFF);
    wr(2, lo); wr(3, hi);
    @(negedge clk);
    expv = '0;
    for (int n = 0; n < 32; n++) expv[31-n] = pick(codes[n], n, 32'h0, alt_val1, alt_val2, alt_val3);
    check("R6 R7 value select", pad_out, expv);
    check("R6 R7 value select leaves enable", pad_oe, 32'hFFFF_FFFF);
    wr(2, 32'h0); wr(3, 32'h0); wr(4, lo); wr(5, hi);
    @(negedge clk);
    expe = '0;
    for (int n = 0; n < 32; n++) expe[31-n] = pick(codes[n], n, 32'hFFFF_FFFF, alt_en1, alt_en2, alt_en3);
    check("R6 R7 enable select", pad_oe, expe);
    check("R7 enable select leaves value", pad_out, 32'h0);
    wr(4, 32'h0); wr(5, 32'h0); wr(1, 32'h0);
    alt_val1 = '0; alt_val2 = '0; alt_val3 = '0; alt_en1 = '0; alt_en2 = '0;
  endtask

  task automatic t_sync();
    logic [31:0] d;
    @(negedge clk);
    bus_addr = 5'd7;
    pin_in = 32'hC3C3_0001;
    @(posedge clk); #1;
    check("R8 not visible after one edge", bus_rdata, 32'h0);
    @(posedge clk); #1;
    check("R8 visible after two edges", bus_rdata, 32'hC3C3_0001);
    rd(7, d);
    check("R8 steady", d, 32'hC3C3_0001);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(7, 32'h1234_5678);
    rd(7, d);
    check("R9 input write ignored", d, 32'hC3C3_0001);
    wr(11, 32'hFFFF_FFFF);
    rd(11, d);
    check("R9 reserved reads zero", d, 32'h0);
    wr(20, 32'hFFFF_FFFF);
    rd(20, d);
    check("R9 unmapped reads zero", d, 32'h0);
    check("R9 pads unaffected", pad_oe, 32'h0);
  endtask

  task automatic t_storage();
    logic [31:0] d;
    for (int a = 8; a < 18; a++) if (a != 11) wr(a, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R10 storage no pad_oe effect", pad_oe, 32'h0);
    check("R10 storage no pad_out effect", pad_out, 32'h0);
    rd(15, d);
    check("R10 storage holds", d, 32'hFFFF_FFFF);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_bit_order();
        t_push_pull();
        t_open_drain();
        t_select();
        t_sync();
        t_ignored();
        t_storage();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule